// File: doc/BRIEF.md
# Timer Channel with Max-Duty Override

This block is a single channel of a free-running timer. A modulo up-counter runs from zero to a programmable terminal value and wraps, raising a one-clock overflow pulse on the wrap. The channel drives one output pin. In output-compare mode the pin can toggle on overflow and can toggle or clear on a compare match. In edge-aligned PWM mode the pin goes high at the start of each period and low on the compare match. A max-duty override can hold the PWM output at full duty, but it only takes effect at a period boundary.

The channel also has an input-capture mode. In that mode the overflow features have no effect and the output pin holds its value. An edge on the capture input is accepted only after the input has been steady for a set number of clocks. Each accepted edge latches the counter value. Software configures the channel through a small write-only register port: address 0 holds the terminal count, address 1 holds the compare value, and address 2 holds the control word.

Top module: `tmr_chan_top`

## Requirements
- R1: The counter advances by one each clock from 0 up to the terminal count (address 0) and then returns to 0. `ovf_o` is high during exactly the clock whose count equals the terminal count.
- R2: In output-compare mode (control bits [3:2] = 00), the pin toggles at each overflow when the toggle-on-overflow bit (control bit 0) is 1. When that bit is 0, an overflow leaves the pin unchanged.
- R3: When toggle-on-overflow is 1 and an overflow and a compare match fall on the same clock, only the overflow action happens and the compare action is dropped.
- R4: In output-compare mode, a compare match (count equals the address 1 value) toggles the pin when the clear-on-match bit (control bit 4) is 0. When that bit is 1, the match drives the pin low.
- R5: In PWM mode (control bits [3:2] = 01) with toggle-on-overflow set, the pin is high for compare+1 clocks of each period. A compare value of 0 gives 0 clocks high. A compare value above the terminal count gives a full period high.
- R6: Setting or clearing the max-duty bit (control bit 1) in PWM mode takes effect only from the next overflow. While the override is in effect, the pin is high for every clock of the period and compare matches are ignored.
- R7: The max-duty bit has no effect while toggle-on-overflow is 0.
- R8: In capture mode (control bit 3 = 1), overflows and compare matches leave the output pin unchanged, whatever the toggle-on-overflow bit says.
- R9: In capture mode, a change of `cap_pin_i` is accepted only if the input held its previous level for at least 2 clocks counted inside capture mode. An accepted change pulses `cap_evt_o` for one clock on the next cycle and loads `cap_val_o` with the count seen at the change.
- R10: Reset sets the count to 0, the pin low, the terminal count to all ones, the compare value to 0, all control bits to 0 (output-compare mode), and `cap_evt_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 terminal count, 1 compare, 2 control |
| wr_data | input | 16 | Write data |
| cap_pin_i | input | 1 | Capture input |
| chan_pin_o | output | 1 | Channel output pin |
| ovf_o | output | 1 | Overflow pulse, high on the wrap clock |
| cnt_o | output | 16 | Current counter value |
| cap_evt_o | output | 1 | One-clock pulse after an accepted capture edge |
| cap_val_o | output | 16 | Counter value latched at the last accepted edge |

## Verification
The hardest behaviour to reach from the ports is the max-duty latency. The override bit has to be written part-way through a period, and the bench must then show that the rest of that period still follows the compare, while the whole next period is high. Clearing the bit needs the same check the other way round. The stimulus waits for a chosen mid-period count before each write, then counts high clocks over periods aligned on overflow. The bench creates coincident overflow and compare by setting the compare value equal to the terminal count over two consecutive periods, so that one of them starts with the pin low and toggle can be told apart from clear. It also produces glitches on the capture input that are one clock wide, straight after capture is enabled, and checks that these are rejected.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    // Register addresses of the configuration port
    localparam logic [1:0] ADDR_TERM = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    // Channel operating mode; bit 1 set selects capture
    typedef enum logic [1:0] {
        MODE_OC   = 2'b00,
        MODE_PWM  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_CAPX = 2'b11
    } chan_mode_e;

    // Control word, packed so that bit 0 is the overflow-toggle enable
    typedef struct packed {
        logic       clr_on_match;  // bit 4
        chan_mode_e mode;          // bits 3:2
        logic       max_duty;      // bit 1
        logic       ovf_toggle;    // bit 0
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    function automatic logic is_capture(input chan_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_chan_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] TERM_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] term_o,
    output logic [CNT_W-1:0] cmp_o,
    output chan_ctrl_t       ctrl_o
);

    typedef struct packed {
        logic [CNT_W-1:0] term;
        logic [CNT_W-1:0] cmp;
        chan_ctrl_t       ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_TERM: st_d.term = wr_data;
                ADDR_CMP:  st_d.cmp  = wr_data;
                ADDR_CTRL: st_d.ctrl = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.term <= TERM_RST;
            st_q.cmp  <= '0;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o = st_q.term;
    assign cmp_o  = st_q.cmp;
    assign ctrl_o = st_q.ctrl;

    // A write to one address never disturbs the terminal count held elsewhere
    p_term_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_TERM) |=> term_o == $past(term_o));

endmodule

// File: rtl/tmr_modcnt.sv
module tmr_modcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_term;

    always_comb begin
        st_d    = st_q;
        at_term = (st_q.cnt == term_i);
        if (at_term) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = at_term;

    // R1: the wrap follows the overflow clock
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> cnt_o == '0);

    // R1: away from overflow the count steps by one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_o |=> cnt_o == $past(cnt_o) + ONE);

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             ovf_i,
    input  chan_ctrl_t       ctrl_i,
    output logic             pin_o
);

    typedef struct packed {
        logic pin;
        logic max_eff;   // override sampled at the period boundary
    } out_st_t;

    out_st_t st_d, st_q;
    logic    cmp_hit;
    logic    cmp_nonzero;
    logic    tov_act;

    always_comb begin
        st_d        = st_q;
        cmp_hit     = (cnt_i == cmp_i);
        cmp_nonzero = (cmp_i != '0);
        tov_act     = ovf_i && ctrl_i.ovf_toggle;

        unique case (ctrl_i.mode)
            MODE_PWM: begin
                if (ovf_i) begin
                    st_d.max_eff = ctrl_i.max_duty && ctrl_i.ovf_toggle;
                end
                if (tov_act) begin
                    st_d.pin = st_d.max_eff || cmp_nonzero;
                end else if (ovf_i && !cmp_hit) begin
                    st_d.pin = st_q.pin;
                end else if (cmp_hit && !st_q.max_eff) begin
                    st_d.pin = 1'b0;
                end
            end
            MODE_OC: begin
                st_d.max_eff = 1'b0;
                if (tov_act) begin
                    st_d.pin = !st_q.pin;
                end else if (cmp_hit) begin
                    st_d.pin = ctrl_i.clr_on_match ? 1'b0 : !st_q.pin;
                end
            end
            default: begin
                // capture: overflow and compare leave the pin alone
                st_d.max_eff = 1'b0;
                st_d.pin     = st_q.pin;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;

    // R2: overflow toggles the pin in compare mode when enabled
    p_oc_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == MODE_OC && ctrl_i.ovf_toggle && ovf_i) |=> pin_o != $past(pin_o));

    // R2: overflow without a match is silent when the toggle is off
    p_oc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == MODE_OC && !ctrl_i.ovf_toggle && ovf_i && cnt_i != cmp_i)
        |=> $stable(pin_o));

    // R3: a coincident clear-on-match is dropped in favour of the toggle
    p_ovf_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == MODE_OC && ctrl_i.ovf_toggle && ovf_i && cnt_i == cmp_i && !pin_o)
        |=> pin_o);

    // R6: once the override is in force the pin stays high inside the period
    p_max_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.mode == MODE_PWM && st_q.max_eff && !ovf_i) |=> pin_o);

    // R8: capture mode freezes the output
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_capture(ctrl_i.mode) |=> $stable(pin_o));

endmodule

// File: rtl/tmr_cap_filter.sv
module tmr_cap_filter #(
    parameter int CNT_W       = 16,
    parameter int STAB_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             evt_o,
    output logic [CNT_W-1:0] val_o
);

    localparam int             SW     = $clog2(STAB_CYCLES + 1);
    localparam logic [SW-1:0]  STAB_N = SW'(STAB_CYCLES);
    localparam logic [SW-1:0]  S_ONE  = SW'(1);

    typedef struct packed {
        logic             prev;
        logic [SW-1:0]    stab;
        logic             evt;
        logic [CNT_W-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    changed;
    logic    armed;

    always_comb begin
        st_d    = st_q;
        changed = (pin_i != st_q.prev);
        armed   = (st_q.stab >= STAB_N);

        st_d.prev = pin_i;
        st_d.evt  = cap_en_i && changed && armed;
        if (st_d.evt) begin
            st_d.val = cnt_i;
        end

        if (!cap_en_i || changed) begin
            st_d.stab = '0;
        end else if (!armed) begin
            st_d.stab = st_q.stab + S_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign val_o = st_q.val;

    // R9: no capture event is produced outside capture mode
    p_no_evt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> !evt_o);

    // R9: an accepted edge restarts the stability window, so events never abut
    p_evt_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    // R9: the captured value only moves together with an event
    p_val_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_o |-> $stable(val_o));

endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_chan_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               STAB_CYCLES = 2,
    parameter logic [CNT_W-1:0] TERM_RST    = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_pin_i,
    output logic             chan_pin_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cap_evt_o,
    output logic [CNT_W-1:0] cap_val_o
);

    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cmp;
    chan_ctrl_t       ctrl;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    tmr_chan_regs #(
        .CNT_W    (CNT_W),
        .TERM_RST (TERM_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .term_o  (term),
        .cmp_o   (cmp),
        .ctrl_o  (ctrl)
    );

    tmr_modcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .term_i (term),
        .cnt_o  (cnt),
        .ovf_o  (ovf)
    );

    tmr_chan_out #(
        .CNT_W (CNT_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt),
        .cmp_i  (cmp),
        .ovf_i  (ovf),
        .ctrl_i (ctrl),
        .pin_o  (chan_pin_o)
    );

    tmr_cap_filter #(
        .CNT_W       (CNT_W),
        .STAB_CYCLES (STAB_CYCLES)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en_i (is_capture(ctrl.mode)),
        .pin_i    (cap_pin_i),
        .cnt_i    (cnt),
        .evt_o    (cap_evt_o),
        .val_o    (cap_val_o)
    );

    assign ovf_o = ovf;
    assign cnt_o = cnt;

endmodule

// File: tb/tb_tmr_chan_top.sv
module tb_tmr_chan_top;

    localparam int TERM = 9;
    localparam int PER  = TERM + 1;
    localparam int WDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cap_pin_i = 1'b0;
    logic        chan_pin_o;
    logic        ovf_o;
    logic [15:0] cnt_o;
    logic        cap_evt_o;
    logic [15:0] cap_val_o;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int evt_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_chan_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cap_pin_i  (cap_pin_i),
        .chan_pin_o (chan_pin_o),
        .ovf_o      (ovf_o),
        .cnt_o      (cnt_o),
        .cap_evt_o  (cap_evt_o),
        .cap_val_o  (cap_val_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_term, m_cmp, m_mode, m_capval, m_stab;
    bit m_tov, m_max, m_clr, m_pin, m_maxeff, m_prev, m_evt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_term = 65535; m_cmp = 0; m_mode = 0;
            m_tov = 0; m_max = 0; m_clr = 0; m_pin = 0; m_maxeff = 0;
            m_prev = 0; m_stab = 0; m_evt = 0; m_capval = 0;
        end else begin
            bit ov, hit, n_pin, n_maxeff, n_evt, chg;
            int n_stab, n_capval;
            ov = (m_cnt == m_term);
            hit = (m_cnt == m_cmp);
            n_pin = m_pin; n_maxeff = m_maxeff;
            if (m_mode == 1) begin
                if (ov) n_maxeff = m_max && m_tov;
                if (ov && m_tov) n_pin = n_maxeff || (m_cmp != 0);
                else if (ov && !hit) n_pin = m_pin;
                else if (hit && !m_maxeff) n_pin = 0;
            end else if (m_mode == 0) begin
                n_maxeff = 0;
                if (ov && m_tov) n_pin = !m_pin;
                else if (hit) n_pin = m_clr ? 1'b0 : !m_pin;
            end else begin
                n_maxeff = 0;
            end
            chg = (cap_pin_i != m_prev);
            n_evt = (m_mode >= 2) && chg && (m_stab >= 2);
            n_capval = n_evt ? m_cnt : m_capval;
            if (m_mode < 2 || chg) n_stab = 0;
            else n_stab = (m_stab < 2) ? m_stab + 1 : m_stab;
            m_pin = n_pin; m_maxeff = n_maxeff; m_evt = n_evt;
            m_capval = n_capval; m_stab = n_stab; m_prev = cap_pin_i;
            m_cnt = ov ? 0 : (m_cnt + 1) % 65536;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_term = int'(wr_data);
                    2'd1: m_cmp = int'(wr_data);
                    2'd2: begin
                        m_tov = wr_data[0]; m_max = wr_data[1];
                        m_mode = int'(wr_data[3:2]); m_clr = wr_data[4];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic string pin_tag(int mode);
        if (mode == 1) return "R5/R6/R7";
        if (mode >= 2) return "R8";
        return "R2/R3/R4";
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(cnt_o) == m_cnt, "R1", "count", int'(cnt_o), m_cnt);
            chk(ovf_o == (m_cnt == m_term), "R1", "overflow", int'(ovf_o), int'(m_cnt == m_term));
            chk(chan_pin_o == m_pin, pin_tag(m_mode), "pin", int'(chan_pin_o), int'(m_pin));
            chk(cap_evt_o == m_evt, "R9", "capture event", int'(cap_evt_o), int'(m_evt));
            if (m_evt) chk(int'(cap_val_o) == m_capval, "R9", "capture value", int'(cap_val_o), m_capval);
            if (cap_evt_o) evt_seen++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_ovf();
        do @(negedge clk); while (!ovf_o);
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt_o) != v);
    endtask

    task automatic count_period(output int n);
        sync_ovf();
        n = 0;
        repeat (PER) begin
            @(negedge clk);
            if (chan_pin_o) n++;
        end
    endtask

    initial begin
        int a, b, n, e0;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(chan_pin_o == 1'b0, "R10", "pin in reset", int'(chan_pin_o), 0);
        chk(cnt_o == 16'd0, "R10", "count in reset", int'(cnt_o), 0);
        chk(cap_evt_o == 1'b0, "R10", "capture event in reset", int'(cap_evt_o), 0);
        chk(ovf_o == 1'b0, "R10", "overflow in reset", int'(ovf_o), 0);
        rst_n = 1'b1;
        wr(2'd0, TERM);
        wr(2'd1, 15);

        // R2: overflow toggle on / off in compare mode
        wr(2'd2, 1);
        sync_ovf(); a = int'(chan_pin_o); @(negedge clk); b = int'(chan_pin_o);
        chk(b != a, "R2", "toggle on overflow", b, 1 - a);
        wr(2'd2, 0);
        sync_ovf(); a = int'(chan_pin_o); @(negedge clk); b = int'(chan_pin_o);
        chk(b == a, "R2", "no toggle when disabled", b, a);

        // R4: compare toggles, then clears
        wr(2'd1, 4);
        wait_cnt(4); a = int'(chan_pin_o); @(negedge clk); b = int'(chan_pin_o);
        chk(b != a, "R4", "toggle on match", b, 1 - a);
        wr(2'd2, 16);
        repeat (2) begin
            wait_cnt(4); @(negedge clk);
            chk(chan_pin_o == 1'b0, "R4", "clear on match", int'(chan_pin_o), 0);
        end

        // R3: coincident overflow and clear-on-match, toggle wins
        wr(2'd1, TERM);
        wr(2'd2, 17);
        repeat (2) begin
            sync_ovf(); a = int'(chan_pin_o); @(negedge clk); b = int'(chan_pin_o);
            chk(b == 1 - a, "R3", "overflow wins over match", b, 1 - a);
        end

        // R5: PWM duty
        wr(2'd1, 3);
        wr(2'd2, 5);
        count_period(n); chk(n == 4, "R5", "high clocks cmp=3", n, 4);
        wr(2'd1, 0);
        count_period(n); chk(n == 0, "R5", "high clocks cmp=0", n, 0);
        wr(2'd1, 12);
        count_period(n); chk(n == PER, "R5", "high clocks cmp>term", n, PER);
        wr(2'd1, 3);
        count_period(n); chk(n == 4, "R5", "high clocks cmp=3 again", n, 4);

        // R6: max-duty set mid period, effective from next boundary
        wait_cnt(5);
        wr(2'd2, 7);
        chk(chan_pin_o == 1'b0, "R6", "set not yet effective", int'(chan_pin_o), 0);
        count_period(n); chk(n == PER, "R6", "full duty period", n, PER);
        wait_cnt(5);
        wr(2'd2, 5);
        do begin
            @(negedge clk);
            chk(chan_pin_o == 1'b1, "R6", "clear not yet effective", int'(chan_pin_o), 1);
        end while (!ovf_o);
        count_period(n); chk(n == 4, "R6", "duty after clear", n, 4);

        // R7: max-duty without overflow toggle is ignored
        wr(2'd2, 6);
        count_period(n);
        count_period(n); chk(n == 0, "R7", "max without toggle", n, 0);

        // R8: capture mode holds the pin
        wr(2'd2, 9);
        a = int'(chan_pin_o);
        repeat (3 * PER) begin
            @(negedge clk);
            chk(int'(chan_pin_o) == a, "R8", "pin frozen in capture", int'(chan_pin_o), a);
        end

        // R9: stable edge accepted, short glitch back rejected
        e0 = evt_seen;
        cap_pin_i = 1'b1; @(negedge clk);
        cap_pin_i = 1'b0;
        repeat (4) @(negedge clk);
        cap_pin_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(evt_seen - e0 == 2, "R9", "events from glitch sequence", evt_seen - e0, 2);

        // R9: edge right after enabling capture is rejected
        wr(2'd2, 0);
        wr(2'd2, 8);
        e0 = evt_seen;
        cap_pin_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(evt_seen - e0 == 0, "R9", "edge too soon after enable", evt_seen - e0, 0);
        cap_pin_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(evt_seen - e0 == 1, "R9", "edge after stable window", evt_seen - e0, 1);

        repeat (5) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule